// File: doc/BRIEF.md
# Shadowed Byte SRAM with Store/Recall Sequencer

This block models a byte-wide static RAM in which every location has a nonvolatile shadow twin. Host reads and writes use active-low chip-select, write-strobe and output-enable pins, and a bidirectional data bus. An open-drain busy line is shared with the host. The block pulls this line low while it moves the whole array between the two planes. The host may also pull the line low itself to ask for a save.

A save copies every SRAM byte into the shadow plane in one step. It can be started in three ways: a one-cycle software strobe, a power-fail comparator level, or an external low on the busy line. The power-fail and busy-line requests are honoured only when the array holds unsaved writes. A restore copies the shadow plane back into the SRAM, and it runs by itself after every reset. A saturating counter records completed saves so that wear can be checked. The address width, the two operation lengths and the counter ceiling are parameters. The default build is kept small for elaboration; AW=15 gives a 32 KiB array.

Top module: `shadowed_sram`

## Requirements
- R1: When `ce_n`=0, `oe_n`=0, `we_n`=1, the busy line reads high and no save or restore is running, `dq` drives the byte stored at `addr` in the same cycle.
- R2: In every other case `dq` is left undriven. In particular, `we_n`=0 turns the drivers off even when `oe_n`=0.
- R3: On a rising clock edge with `ce_n`=0, `we_n`=0, the busy line high and no operation running, the value on `dq` is written to `addr`.
- R4: After reset is released, a restore runs for exactly RECALL_CYC clock edges. During reset and during the restore, `busy_n` is held low. At the end, every SRAM byte equals its shadow byte.
- R5: A one-cycle `sw_store`=1 always starts a save. A high `pwr_fail` level, or an external low on `busy_n` sampled while idle, starts a save only when an unsaved write exists.
- R6: A save holds `busy_n` low for exactly STORE_CYC clock edges after the edge that starts it. At the end, every shadow byte equals its SRAM byte.
- R7: While a save or restore runs, writes have no effect on the array and `dq` is not driven.
- R8: The unsaved-write flag is set by each committed write and cleared when a save or restore completes. A trigger that stays active after its save, or a trigger raised just after a restore, therefore starts nothing.
- R9: `store_count` is 0 after reset. It rises by one on each completed save and saturates at MAX_STORES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts a restore when released |
| addr | input | AW | Byte address |
| dq | inout | 8 | Bidirectional data bus |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| busy_n | inout | 1 | Open-drain busy line: driven low by the block during save or restore; a host low requests a save |
| pwr_fail | input | 1 | Supply-below-threshold indication |
| sw_store | input | 1 | Software save request, one-cycle strobe |
| store_count | output | CNT_W | Saturating count of completed saves |

## Verification
The bench builds the block with AW=4, STORE_CYC=5, RECALL_CYC=3 and MAX_STORES=4. The sixteen-byte array can then be written and read back in full with an address-derived pattern, and both planes can be compared after a power cycle. The short operation lengths let the bench check the busy line on every edge of each save and restore. The low ceiling brings counter saturation within a handful of software saves.

// File: rtl/shsram_pkg.sv
`timescale 1ns/1ps
package shsram_pkg;

  typedef enum logic [1:0] {
    OP_RECALL = 2'd0,
    OP_IDLE   = 2'd1,
    OP_STORE  = 2'd2
  } op_state_e;

  // decides whether an idle sequencer launches a save this cycle
  function automatic logic store_go(input logic sw, input logic pf,
                                    input logic hw_low, input logic dirty);
    return sw | (dirty & (pf | hw_low));
  endfunction

  // saturating increment of the save counter
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/shsram_seq.sv
`timescale 1ns/1ps
module shsram_seq
  import shsram_pkg::*;
#(
  parameter int unsigned STORE_CYC  = 16,
  parameter int unsigned RECALL_CYC = 8,
  parameter int unsigned MAX_STORES = 200000,
  localparam int unsigned CNT_W = $clog2(MAX_STORES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_store,
  input  logic             pwr_fail,
  input  logic             hw_req_low,
  input  logic             wr_commit,
  output logic             op_active,
  output logic             store_start,
  output logic             store_done,
  output logic             recall_done,
  output logic [CNT_W-1:0] store_count
);

  localparam int unsigned LONGEST = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int unsigned TW      = $clog2(LONGEST + 1);

  op_state_e       st;
  logic [TW-1:0]   tick;
  logic            dirty;
  logic            last_tick;

  assign last_tick   = (st == OP_STORE) ? (tick == TW'(STORE_CYC - 1))
                                        : (tick == TW'(RECALL_CYC - 1));
  assign op_active   = (st != OP_IDLE);
  assign store_done  = (st == OP_STORE)  && last_tick;
  assign recall_done = (st == OP_RECALL) && last_tick;
  assign store_start = (st == OP_IDLE) && store_go(sw_store, pwr_fail, hw_req_low, dirty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= OP_RECALL;
      tick <= '0;
    end else begin
      unique case (st)
        OP_IDLE: begin
          tick <= '0;
          if (store_start) st <= OP_STORE;
        end
        OP_STORE, OP_RECALL: begin
          if (last_tick) begin
            st   <= OP_IDLE;
            tick <= '0;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: st <= OP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         dirty <= 1'b0;
    else if (store_done || recall_done) dirty <= 1'b0;
    else if (wr_commit)                 dirty <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          store_count <= '0;
    else if (store_done) store_count <= CNT_W'(sat_inc(32'(store_count), MAX_STORES));
  end

  // R5: a save only launches on a software strobe or with unsaved writes
  p_store_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> (sw_store || dirty));

  // R6: the save timer never passes its length
  p_store_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == OP_STORE) |-> (tick < TW'(STORE_CYC)));

  // R8: completion leaves no unsaved-write mark behind
  p_dirty_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (store_done || recall_done) |=> !dirty);

  // R9: counter steps by one below the ceiling and never exceeds it
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (store_done && store_count < CNT_W'(MAX_STORES)) |=> store_count == $past(store_count) + 1'b1);
  p_count_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    store_count <= CNT_W'(MAX_STORES));

endmodule

// File: rtl/shsram_array.sv
`timescale 1ns/1ps
module shsram_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_active,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic          do_store,
  input  logic          do_recall,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] sram   [DEPTH];
  logic [DW-1:0] shadow [DEPTH];

  assign rd_data = sram[addr];

  // volatile plane: restore overrides any host write
  always_ff @(posedge clk) begin
    if (do_recall) begin
      for (int i = 0; i < DEPTH; i++) sram[i] <= shadow[i];
    end else if (wr_en) begin
      sram[addr] <= wr_data;
    end
  end

  // nonvolatile plane: whole-array copy in one edge
  always_ff @(posedge clk) begin
    if (do_store) begin
      for (int i = 0; i < DEPTH; i++) shadow[i] <= sram[i];
    end
  end

  // R7: no host write reaches the array while a transfer runs
  p_wr_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !op_active);

  // R4/R6: the two copy directions never coincide
  p_one_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_store && do_recall));

endmodule

// File: rtl/shsram_bus.sv
`timescale 1ns/1ps
module shsram_bus (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic busy_line,
  input  logic op_active,
  output logic rd_drive,
  output logic wr_en,
  output logic hw_req_low
);

  logic host_ok;

  // access allowed only when the line is high and no transfer runs
  assign host_ok    = busy_line && !op_active;
  assign wr_en      = !ce_n && !we_n && host_ok;
  assign rd_drive   = !ce_n && !oe_n && we_n && host_ok;
  // while idle the block never pulls the line, so a low comes from the host
  assign hw_req_low = !busy_line && !op_active;

  // R2: a low write strobe always silences the drivers
  p_we_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !rd_drive);

  // R2: reads and writes are mutually exclusive
  p_rw_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_drive && wr_en));

endmodule

// File: rtl/shadowed_sram.sv
`timescale 1ns/1ps
module shadowed_sram #(
  parameter int unsigned AW         = 8,
  parameter int unsigned STORE_CYC  = 16,
  parameter int unsigned RECALL_CYC = 8,
  parameter int unsigned MAX_STORES = 200000,
  localparam int unsigned DW    = 8,
  localparam int unsigned CNT_W = $clog2(MAX_STORES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  inout  wire  [DW-1:0]    dq,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  inout  wire              busy_n,
  input  logic             pwr_fail,
  input  logic             sw_store,
  output logic [CNT_W-1:0] store_count
);

  logic          op_active;
  logic          store_start;
  logic          store_done;
  logic          recall_done;
  logic          rd_drive;
  logic          wr_en;
  logic          hw_req_low;
  logic [DW-1:0] rd_data;
  logic          busy_line;

  assign busy_line = busy_n;
  assign busy_n    = op_active ? 1'b0 : 1'bz;
  assign dq        = rd_drive ? rd_data : {DW{1'bz}};

  shsram_bus u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .busy_line  (busy_line),
    .op_active  (op_active),
    .rd_drive   (rd_drive),
    .wr_en      (wr_en),
    .hw_req_low (hw_req_low)
  );

  shsram_seq #(
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC),
    .MAX_STORES (MAX_STORES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_store    (sw_store),
    .pwr_fail    (pwr_fail),
    .hw_req_low  (hw_req_low),
    .wr_commit   (wr_en),
    .op_active   (op_active),
    .store_start (store_start),
    .store_done  (store_done),
    .recall_done (recall_done),
    .store_count (store_count)
  );

  shsram_array #(
    .AW (AW),
    .DW (DW)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_active (op_active),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (dq),
    .do_store  (store_done),
    .do_recall (recall_done),
    .rd_data   (rd_data)
  );

  // R7: the data bus is quiet whenever the block holds the busy line
  p_quiet_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_active |-> !rd_drive);

  // R6: a launched save keeps the block busy on the following cycle
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |=> op_active);

endmodule

// File: tb/shadowed_sram_bench.sv
`timescale 1ns/1ps
module shadowed_sram_bench;

  localparam int unsigned AW  = 4;
  localparam int unsigned SC  = 5;
  localparam int unsigned RC  = 3;
  localparam int unsigned MX  = 4;
  localparam int unsigned N   = 1 << AW;
  localparam int unsigned CW  = $clog2(MX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic          pwr_fail = 1'b0, sw_store = 1'b0;
  logic          host_en = 1'b0, host_pull = 1'b0;
  logic [7:0]    host_data = '0;
  logic [CW-1:0] store_count;
  wire  [7:0]    dq;
  wire           busy_n;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [7:0] model [N];

  always #10 clk = ~clk;

  assign dq     = host_en   ? host_data : 8'hzz;
  assign busy_n = host_pull ? 1'b0      : 1'bz;
  pullup (busy_n);
  for (genvar g = 0; g < 8; g++) begin : g_pu
    pullup (dq[g]);
  end

  shadowed_sram #(
    .AW(AW), .STORE_CYC(SC), .RECALL_CYC(RC), .MAX_STORES(MX)
  ) u_shadowed_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dq(dq), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .busy_n(busy_n), .pwr_fail(pwr_fail), .sw_store(sw_store),
    .store_count(store_count)
  );

  function automatic logic [7:0] pat_a(input int a);
    return {4'(a), 4'(~a)};
  endfunction
  function automatic logic [7:0] pat_b(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction
  function automatic int sat_next(input int v);
    return (v + 1 > MX) ? MX : v + 1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = AW'(a);
    host_data = d; host_en = 1'b1;
    cyc(1);
    ce_n = 1'b1; we_n = 1'b1; host_en = 1'b0;
  endtask

  task automatic rd(input string req, input int a, input logic [7:0] exp);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = AW'(a);
    #1;
    chk(req, $sformatf("read addr %0d", a), int'(dq), int'(exp));
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  // reset pulse followed by the automatic restore
  task automatic power_cycle();
    rst_n = 1'b0;
    cyc(2);
    chk("R4", "busy low in reset", int'(busy_n), 0);
    chk("R9", "count cleared", int'(store_count), 0);
    rst_n = 1'b1;
    ce_n = 1'b0; oe_n = 1'b0; addr = '0;
    for (int k = 1; k <= RC; k++) begin
      cyc(1);
      if (k == 1) begin
        chk("R7", "dq undriven during restore", int'(dq), 8'hFF);
        ce_n = 1'b1; oe_n = 1'b1;
      end
      chk("R4", $sformatf("busy after restore edge %0d", k), int'(busy_n), (k == RC) ? 1 : 0);
    end
  endtask

  // follows a save launched by the stimulus set just before the call
  task automatic run_store(input int exp_cnt);
    for (int j = 0; j <= SC; j++) begin
      cyc(1);
      if (j == 0) begin
        sw_store = 1'b0; host_pull = 1'b0;
      end
      chk("R6", $sformatf("busy in save step %0d", j), int'(busy_n), (j == SC) ? 1 : 0);
    end
    chk("R9", "count after save", int'(store_count), exp_cnt);
  endtask

  initial begin
    int cnt;
    cyc(1);
    power_cycle();

    // R8/R5: no writes since restore, so level and line triggers are ignored
    pwr_fail = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cyc(1);
      chk("R8", "power-fail ignored when clean", int'(busy_n), 1);
    end
    pwr_fail = 1'b0;
    host_pull = 1'b1;
    cyc(1);
    host_pull = 1'b0;
    cyc(1);
    chk("R5", "line pull ignored when clean", int'(busy_n), 1);
    chk("R8", "no save counted", int'(store_count), 0);

    // R3/R1: fill and read back the whole array
    for (int a = 0; a < N; a++) begin
      wr(a, pat_a(a));
      model[a] = pat_a(a);
    end
    for (int a = 0; a < N; a++) rd("R1", a, model[a]);

    // R2: control sweep with the write strobe high
    for (int c = 0; c < 4; c++) begin
      ce_n = c[0]; oe_n = c[1]; we_n = 1'b1; addr = 4'd3;
      #1;
      chk("R2", $sformatf("ce_n=%0d oe_n=%0d", c[0], c[1]), int'(dq),
          (c == 0) ? int'(model[3]) : 8'hFF);
    end
    ce_n = 1'b1; oe_n = 1'b1;
    // R2: write strobe low with output enable low, bus released by host
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 4'd9;
    #1;
    chk("R2", "we_n low silences drivers", int'(dq), 8'hFF);
    cyc(1);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    model[9] = 8'hFF;
    rd("R3", 9, 8'hFF);

    // R5/R6/R7: power-fail save with blocked accesses inside it
    pwr_fail = 1'b1;
    for (int j = 0; j <= SC; j++) begin
      cyc(1);
      if (j == 1) begin
        ce_n = 1'b0; we_n = 1'b0; addr = 4'd5; host_data = 8'h99; host_en = 1'b1;
      end
      if (j == 2) begin
        we_n = 1'b1; host_en = 1'b0; oe_n = 1'b0;
        #1;
        chk("R7", "dq undriven during save", int'(dq), 8'hFF);
        ce_n = 1'b1; oe_n = 1'b1;
      end
      chk("R6", $sformatf("busy in power-fail save %0d", j), int'(busy_n), (j == SC) ? 1 : 0);
    end
    chk("R9", "first save counted", int'(store_count), 1);
    for (int k = 0; k < 3; k++) begin
      cyc(1);
      chk("R8", "held power-fail after save ignored", int'(busy_n), 1);
    end
    chk("R8", "still one save", int'(store_count), 1);
    pwr_fail = 1'b0;
    rd("R7", 5, model[5]);

    // overwrite the volatile plane, then power cycle
    for (int a = 0; a < N; a++) wr(a, pat_b(a));
    rd("R3", 7, pat_b(7));
    power_cycle();
    for (int a = 0; a < N; a++) rd("R4", a, model[a]);

    // R8: line pull right after restore ignored; after a write it saves
    host_pull = 1'b1;
    cyc(1);
    host_pull = 1'b0;
    cyc(1);
    chk("R8", "line pull ignored after restore", int'(busy_n), 1);
    wr(2, 8'h3C);
    model[2] = 8'h3C;
    host_pull = 1'b1;
    run_store(1);

    // R5/R9: software saves always run, count saturates
    cnt = 1;
    for (int s = 0; s < 5; s++) begin
      sw_store = 1'b1;
      cnt = sat_next(cnt);
      run_store(cnt);
    end
    chk("R9", "count at ceiling", int'(store_count), MX);

    // R6: shadow holds the last save; restore brings it back
    wr(2, 8'h11);
    power_cycle();
    rd("R6", 2, 8'h3C);
    rd("R6", 0, model[0]);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not end");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule